// File: doc/BRIEF.md
# FEC Codeword Marker Mapper and Rebuilder

This block sits beside a single-lane Reed-Solomon FEC sublayer and handles the codeword markers that flag RS codeword boundaries. On the transmit side it accepts a group of four 66-bit markers and folds them into a 257-bit vector. That vector carries the 64-bit payload of each marker, with the sync headers stripped, plus a flag bit set to one. The vector is presented, tagged as valid, for the codeword whose 10-bit codeword counter reads zero, which is the one codeword in every 1024 that starts with the marker group.

On the receive side the block takes the 257-bit vector that was pulled from the front of that same codeword. It rebuilds four complete 66-bit markers. Only the two variable bytes of each marker are carried through the mapped vector. The sync header and the six fixed bytes of each lane are regenerated from a per-lane constant table given as a parameter. The rebuilt markers leave one per cycle over four consecutive cycles, in ascending lane order, with the lane index shown beside them.

Top module: `fec_cwm_mapper`

## Requirements
- R1: On transmit, mapped bits [64x+63:64x] equal marker x bits [65:2] for every lane x in 0..3. Marker x occupies `tx_markers_i[66x+65:66x]`, and its bit 0 is the first bit on the line.
- R2: Bit 256 of every transmit mapped vector is 1.
- R3: Bits [1:0] of each transmit marker (its sync header) have no effect on `tx_map_o`.
- R4: `tx_map_o` and `tx_map_valid_o` update one cycle after a cycle with `tx_valid_i`=1 and `tx_cw_count_i`=0. `tx_map_valid_o` is high only in that cycle. In every other case `tx_map_o` holds its value, including when `tx_valid_i` is high with a nonzero count.
- R5: Every rebuilt receive marker has bit 0 = 1 and bit 1 = 0.
- R6: Rebuilt marker bits [25:2] and [57:34] of lane x come from the parameter table entry for lane x. Entry bits [23:0] hold bytes M0 (low), M1, M2 and go to marker bits [25:2]. Entry bits [47:24] hold M4, M5, M6 and go to marker bits [57:34]. The default table holds {M0,M1,M2} / {M4,M5,M6} as follows: lane 0 = 90,76,47 / 6F,89,B8; lane 1 = F0,C4,E6 / 0F,3B,19; lane 2 = C5,65,9B / 3A,9A,64; lane 3 = A2,79,3D / 5D,86,C2 (hex).
- R7: Rebuilt marker bits [33:26] of lane x equal mapped bits [64x+31:64x+24], and marker bits [65:58] equal mapped bits [64x+63:64x+56].
- R8: Received mapped bits outside the two variable bytes of each lane, bit 256 included, have no effect on the rebuilt markers.
- R9: After a cycle with `rx_valid_i`=1 and `rx_cw_count_i`=0, the next four cycles show lanes 0, 1, 2 and 3 on `rx_marker_o`/`rx_lane_o`, one per cycle, with `rx_marker_valid_o` high. The cycle after that has `rx_marker_valid_o` low.
- R10: A receive strobe with a nonzero codeword count neither starts nor disturbs the marker output sequence.
- R11: A new receive capture (count 0) during an ongoing sequence restarts the output at lane 0 with the new markers.
- R12: While reset is held, `tx_map_o`, `rx_marker_o` and `rx_lane_o` are zero and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_markers_i | input | LANES*66 | Four transmit markers, lane x at bits [66x+65:66x] |
| tx_valid_i | input | 1 | Transmit codeword strobe |
| tx_cw_count_i | input | CNT_W | Transmit codeword counter, 0 selects the marker codeword |
| tx_map_o | output | LANES*64+1 | Mapped marker vector |
| tx_map_valid_o | output | 1 | Mapped vector is the head of the marker codeword |
| rx_map_i | input | LANES*64+1 | Vector extracted from the head of a received codeword |
| rx_valid_i | input | 1 | Receive codeword strobe |
| rx_cw_count_i | input | CNT_W | Receive codeword counter, 0 selects the marker codeword |
| rx_marker_o | output | 66 | Rebuilt marker |
| rx_lane_o | output | $clog2(LANES) | Lane index of `rx_marker_o` |
| rx_marker_valid_o | output | 1 | `rx_marker_o` carries a rebuilt marker |

## Verification
The bench pushes sync header values that differ per lane, and fills the known-byte positions of the received vector with junk, including bit 256. A design that forwarded header or known bits, or shifted the payload by the two header bits, would show mismatched vectors or markers. It also sends strobes with nonzero counts, both while idle and in the middle of a receive sequence. A design that ignored the counter would emit spurious vectors, or restart and corrupt the lane order. A second capture during an output sequence checks that the lane index restarts at 0 and does not run out the old group. Each lane is compared against its own constant bytes, so a design that swapped table entries or the order of M bytes would miscompare.

// File: rtl/fec_cwm_pkg.sv
package fec_cwm_pkg;
  localparam int BLK_W   = 66;
  localparam int PAY_W   = 64;
  localparam int CONST_W = 48;
  localparam int BYTE_W  = 8;

  // rebuilt sync header, bit 0 first on the line
  localparam logic [1:0] RX_SH = 2'b01;

  // per lane: [23:0] = {M2,M1,M0}, [47:24] = {M6,M5,M4}
  localparam logic [3:0][CONST_W-1:0] DEF_LANE_CONST = {
    48'hC2865D_3D79A2,
    48'h649A3A_9B65C5,
    48'h193B0F_E6C4F0,
    48'hB8896F_477690
  };
endpackage

// File: rtl/cwm_tx_map.sv
module cwm_tx_map
  import fec_cwm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 10,
  localparam int MAP_W = LANES*PAY_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LANES*BLK_W-1:0] markers_i,
  input  logic                   valid_i,
  input  logic [CNT_W-1:0]       cnt_i,
  output logic [MAP_W-1:0]       map_o,
  output logic                   map_valid_o
);
  logic [MAP_W-1:0]   map_d;
  logic [2*LANES-1:0] unused_sh;
  logic               take;

  assign take = valid_i && (cnt_i == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign map_d[l*PAY_W +: PAY_W] = markers_i[l*BLK_W + 2 +: PAY_W];
    assign unused_sh[2*l +: 2]     = markers_i[l*BLK_W +: 2];
  end
  assign map_d[MAP_W-1] = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_o       <= '0;
      map_valid_o <= 1'b0;
    end else begin
      map_valid_o <= take;
      if (take) map_o <= map_d;
    end
  end
endmodule

// File: rtl/cwm_lane_build.sv
module cwm_lane_build
  import fec_cwm_pkg::*;
#(
  parameter logic [CONST_W-1:0] KNOWN = DEF_LANE_CONST[0]
) (
  input  logic [BYTE_W-1:0] var_lo_i,
  input  logic [BYTE_W-1:0] var_hi_i,
  output logic [BLK_W-1:0]  blk_o
);
  assign blk_o = {var_hi_i, KNOWN[47:24], var_lo_i, KNOWN[23:0], RX_SH};
endmodule

// File: rtl/cwm_rx_rebuild.sv
module cwm_rx_rebuild
  import fec_cwm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 10,
  parameter logic [LANES-1:0][CONST_W-1:0] LANE_CONST = DEF_LANE_CONST,
  localparam int MAP_W  = LANES*PAY_W + 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAP_W-1:0]  map_i,
  input  logic              valid_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BLK_W-1:0]  marker_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              marker_valid_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES-1);

  logic [LANES-1:0][BLK_W-1:0] blk_d, blk_q;
  logic [LANES*CONST_W:0]      unused_bits;
  logic [LANE_W-1:0]           lane_q;
  logic                        busy_q;
  logic                        take;

  assign take = valid_i && (cnt_i == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cwm_lane_build #(.KNOWN(LANE_CONST[l])) u_build (
      .var_lo_i (map_i[l*PAY_W + 24 +: BYTE_W]),
      .var_hi_i (map_i[l*PAY_W + 56 +: BYTE_W]),
      .blk_o    (blk_d[l])
    );
    assign unused_bits[l*CONST_W +: 24]      = map_i[l*PAY_W +: 24];
    assign unused_bits[l*CONST_W + 24 +: 24] = map_i[l*PAY_W + 32 +: 24];
  end
  assign unused_bits[LANES*CONST_W] = map_i[MAP_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= '0;
      lane_q <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      blk_q  <= blk_d;
      lane_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (lane_q == LAST_LANE) begin
        busy_q <= 1'b0;
        lane_q <= '0;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  assign marker_o       = blk_q[lane_q];
  assign lane_o         = lane_q;
  assign marker_valid_o = busy_q;
endmodule

// File: rtl/fec_cwm_mapper.sv
module fec_cwm_mapper
  import fec_cwm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 10,
  parameter logic [LANES-1:0][CONST_W-1:0] LANE_CONST = DEF_LANE_CONST
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [LANES*66-1:0]                       tx_markers_i,
  input  logic                                      tx_valid_i,
  input  logic [CNT_W-1:0]                          tx_cw_count_i,
  output logic [LANES*64:0]                         tx_map_o,
  output logic                                      tx_map_valid_o,
  input  logic [LANES*64:0]                         rx_map_i,
  input  logic                                      rx_valid_i,
  input  logic [CNT_W-1:0]                          rx_cw_count_i,
  output logic [65:0]                               rx_marker_o,
  output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] rx_lane_o,
  output logic                                      rx_marker_valid_o
);
  cwm_tx_map #(.LANES(LANES), .CNT_W(CNT_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .markers_i   (tx_markers_i),
    .valid_i     (tx_valid_i),
    .cnt_i       (tx_cw_count_i),
    .map_o       (tx_map_o),
    .map_valid_o (tx_map_valid_o)
  );

  cwm_rx_rebuild #(.LANES(LANES), .CNT_W(CNT_W), .LANE_CONST(LANE_CONST)) u_rx (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .map_i          (rx_map_i),
    .valid_i        (rx_valid_i),
    .cnt_i          (rx_cw_count_i),
    .marker_o       (rx_marker_o),
    .lane_o         (rx_lane_o),
    .marker_valid_o (rx_marker_valid_o)
  );
endmodule

// File: rtl/fec_cwm_mapper_chk.sv
module fec_cwm_mapper_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 10,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_valid_i,
  input logic [CNT_W-1:0]   tx_cw_count_i,
  input logic [LANES*64:0]  tx_map_o,
  input logic               tx_map_valid_o,
  input logic               rx_valid_i,
  input logic [CNT_W-1:0]   rx_cw_count_i,
  input logic [65:0]        rx_marker_o,
  input logic [LANE_W-1:0]  rx_lane_o,
  input logic               rx_marker_valid_o
);
  logic tx_take, rx_take;
  assign tx_take = tx_valid_i && (tx_cw_count_i == '0);
  assign rx_take = rx_valid_i && (rx_cw_count_i == '0);

  assert_tx_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_map_valid_o |-> tx_map_o[LANES*64]);

  assert_tx_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |=> tx_map_valid_o);

  assert_tx_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_take |=> !tx_map_valid_o && $stable(tx_map_o));

  assert_rx_header_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_marker_valid_o |-> rx_marker_o[1:0] == 2'b01);

  assert_rx_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_take |=> rx_marker_valid_o && rx_lane_o == '0);

  assert_rx_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_marker_valid_o && !rx_take && rx_lane_o != LANE_W'(LANES-1)
    |=> rx_marker_valid_o && rx_lane_o == $past(rx_lane_o) + 1'b1);

  assert_rx_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_marker_valid_o && !rx_take && rx_lane_o == LANE_W'(LANES-1)
    |=> !rx_marker_valid_o);

  assert_rx_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_marker_valid_o && !rx_take |=> !rx_marker_valid_o);
endmodule

bind fec_cwm_mapper fec_cwm_mapper_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .tx_valid_i        (tx_valid_i),
  .tx_cw_count_i     (tx_cw_count_i),
  .tx_map_o          (tx_map_o),
  .tx_map_valid_o    (tx_map_valid_o),
  .rx_valid_i        (rx_valid_i),
  .rx_cw_count_i     (rx_cw_count_i),
  .rx_marker_o       (rx_marker_o),
  .rx_lane_o         (rx_lane_o),
  .rx_marker_valid_o (rx_marker_valid_o)
);

// File: tb/fec_cwm_mapper_tb_top.sv
module fec_cwm_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CNT_W = 10;

  // bench copy of the R6 table: {M6,M5,M4,M2,M1,M0}
  localparam logic [47:0] K0 = 48'hB8896F_477690;
  localparam logic [47:0] K1 = 48'h193B0F_E6C4F0;
  localparam logic [47:0] K2 = 48'h649A3A_9B65C5;
  localparam logic [47:0] K3 = 48'hC2865D_3D79A2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [263:0]       tx_markers = '0;
  logic               tx_valid = 1'b0;
  logic [CNT_W-1:0]   tx_cnt = '0;
  logic [256:0]       tx_map;
  logic               tx_map_valid;
  logic [256:0]       rx_map = '0;
  logic               rx_valid = 1'b0;
  logic [CNT_W-1:0]   rx_cnt = '0;
  logic [65:0]        rx_marker;
  logic [1:0]         rx_lane;
  logic               rx_marker_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fec_cwm_mapper #(.LANES(LANES), .CNT_W(CNT_W)) dut_i (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .tx_markers_i      (tx_markers),
    .tx_valid_i        (tx_valid),
    .tx_cw_count_i     (tx_cnt),
    .tx_map_o          (tx_map),
    .tx_map_valid_o    (tx_map_valid),
    .rx_map_i          (rx_map),
    .rx_valid_i        (rx_valid),
    .rx_cw_count_i     (rx_cnt),
    .rx_marker_o       (rx_marker),
    .rx_lane_o         (rx_lane),
    .rx_marker_valid_o (rx_marker_valid)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [263:0] act, input logic [263:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] kconst(input int l);
    case (l)
      0: return K0;
      1: return K1;
      2: return K2;
      default: return K3;
    endcase
  endfunction

  function automatic logic [256:0] exp_tx(input logic [263:0] mk);
    logic [256:0] v;
    for (int x = 0; x < 4; x++) v[64*x +: 64] = mk[66*x + 2 +: 64];
    v[256] = 1'b1;
    return v;
  endfunction

  function automatic logic [65:0] exp_rx(input logic [256:0] m, input int l);
    logic [47:0] k;
    k = kconst(l);
    return {m[64*l + 56 +: 8], k[47:24], m[64*l + 24 +: 8], k[23:0], 2'b01};
  endfunction

  function automatic logic [263:0] rnd264();
    logic [263:0] v;
    for (int i = 0; i < 9; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // lanes 0..3 emitted from the cycle after capture, then valid drops
  task automatic rx_expect_seq(input logic [256:0] m, input string req);
    for (int l = 0; l < 4; l++) begin
      check(264'(rx_marker_valid), 264'(1), req);
      check(264'(rx_lane), 264'(l), req);
      check(264'(rx_marker), 264'(exp_rx(m, l)), req);
      step();
    end
    check(264'(rx_marker_valid), 264'(0), req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    check(264'(tx_map), 264'(0), "R12 tx_map");
    check(264'(tx_map_valid), 264'(0), "R12 tx_valid");
    check(264'(rx_marker), 264'(0), "R12 rx_marker");
    check(264'(rx_lane), 264'(0), "R12 rx_lane");
    check(264'(rx_marker_valid), 264'(0), "R12 rx_valid");
    @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_tx_patterns();
    logic [263:0] pats [4];
    pats[0] = {4{66'h2_AAAA_AAAA_AAAA_AAAA}};
    pats[1] = {66'h3_FFFF_FFFF_FFFF_FFFF, 66'h0, 66'h1_2345_6789_ABCD_EF01, 66'h2_0000_0000_0000_0001};
    pats[2] = rnd264();
    pats[3] = rnd264();
    for (int p = 0; p < 4; p++) begin
      tx_markers = pats[p];
      tx_valid = 1'b1;
      tx_cnt = '0;
      step();
      tx_valid = 1'b0;
      check(264'(tx_map_valid), 264'(1), "R4 strobe");
      check(264'(tx_map), 264'(exp_tx(pats[p])), "R1 payload");
      check(264'(tx_map[256]), 264'(1), "R2 flag");
      step();
      check(264'(tx_map_valid), 264'(0), "R4 one cycle");
    end
  endtask

  task automatic t_tx_sync_ignore();
    logic [263:0] a, b;
    logic [256:0] ref_map;
    a = rnd264();
    b = a;
    for (int x = 0; x < 4; x++) begin
      a[66*x +: 2] = 2'(x);
      b[66*x +: 2] = ~2'(x);
    end
    tx_markers = a; tx_valid = 1'b1; tx_cnt = '0;
    step();
    ref_map = tx_map;
    tx_markers = b;
    step();
    tx_valid = 1'b0;
    check(264'(tx_map), 264'(ref_map), "R3 header ignored");
    check(264'(tx_map), 264'(exp_tx(b)), "R3 payload");
  endtask

  task automatic t_tx_count_gate();
    logic [263:0] a, b;
    a = rnd264(); b = ~a;
    tx_markers = a; tx_valid = 1'b1; tx_cnt = '0;
    step();
    tx_markers = b; tx_cnt = 10'd1;
    step();
    check(264'(tx_map_valid), 264'(0), "R4 nonzero count valid");
    check(264'(tx_map), 264'(exp_tx(a)), "R4 hold on count");
    tx_cnt = 10'd1023;
    step();
    check(264'(tx_map), 264'(exp_tx(a)), "R4 hold on 1023");
    tx_valid = 1'b0; tx_cnt = '0;
    step();
    check(264'(tx_map_valid), 264'(0), "R4 no strobe");
    check(264'(tx_map), 264'(exp_tx(a)), "R4 hold idle");
  endtask

  task automatic t_rx_basic();
    logic [256:0] m;
    m = 257'(rnd264());
    rx_map = m; rx_valid = 1'b1; rx_cnt = '0;
    step();
    rx_valid = 1'b0;
    check(264'(rx_marker[1:0]), 264'(2'b01), "R5 header");
    check(264'(rx_marker[25:2]), 264'(K0[23:0]), "R6 lane0 M0-M2");
    check(264'(rx_marker[57:34]), 264'(K0[47:24]), "R6 lane0 M4-M6");
    check(264'(rx_marker[33:26]), 264'(m[31:24]), "R7 lane0 lo byte");
    check(264'(rx_marker[65:58]), 264'(m[63:56]), "R7 lane0 hi byte");
    rx_expect_seq(m, "R9 sequence");
  endtask

  task automatic t_rx_ignore();
    logic [256:0] a, b;
    a = 257'(rnd264());
    b = ~a;
    for (int x = 0; x < 4; x++) begin
      b[64*x + 24 +: 8] = a[64*x + 24 +: 8];
      b[64*x + 56 +: 8] = a[64*x + 56 +: 8];
    end
    rx_map = b; rx_valid = 1'b1; rx_cnt = '0;
    step();
    rx_valid = 1'b0;
    rx_map = '0;
    rx_expect_seq(a, "R8 known bits ignored");
  endtask

  task automatic t_rx_count_gate();
    logic [256:0] a;
    a = 257'(rnd264());
    rx_map = a; rx_valid = 1'b1; rx_cnt = 10'd5;
    step();
    check(264'(rx_marker_valid), 264'(0), "R10 idle nonzero count");
    rx_cnt = '0;
    step();
    rx_map = ~a; rx_cnt = 10'd3;
    rx_expect_seq(a, "R10 mid-sequence count");
    rx_valid = 1'b0; rx_cnt = '0;
  endtask

  task automatic t_rx_restart();
    logic [256:0] a, b;
    a = 257'(rnd264());
    b = 257'(rnd264());
    rx_map = a; rx_valid = 1'b1; rx_cnt = '0;
    step();
    rx_valid = 1'b0;
    check(264'(rx_lane), 264'(0), "R11 first lane");
    step();
    check(264'(rx_lane), 264'(1), "R11 second lane");
    check(264'(rx_marker), 264'(exp_rx(a, 1)), "R11 old lane1");
    rx_map = b; rx_valid = 1'b1;
    step();
    rx_valid = 1'b0;
    rx_expect_seq(b, "R11 restart");
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_patterns();
    t_tx_sync_ignore();
    t_tx_count_gate();
    t_rx_basic();
    t_rx_ignore();
    t_rx_count_gate();
    t_rx_restart();
    step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule